// File: doc/BRIEF.md
# Configurable Open-Drain GPIO Bank

This block drives and watches a small bank of general-purpose pads, four by default. Each pad is set up on its own. As an output it works in open-drain style: it either pulls the pad low or lets go, so an external pull-up takes the pad high. An output can also blink. All blinking pads share a single slow phase generator, which is derived from a 50 kHz base tick and runs at roughly 1.5 Hz, so every blinking pad toggles at the same moment. As an input, the pad level is synchronized and can be read back. Any change of that level, rising or falling, sets a sticky flag in a fault register.

A host reaches four word registers through a single-cycle write port: pad modes, output levels, the fault-enable mask, and a write-1-to-clear register for the fault flags. The synchronized levels, the flags, and a combined fault line come out directly as ports. The fault line is high whenever an enabled flag is set, so an alert reaches the system without any bus traffic.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pad is released (pad_oe all 0), all modes are input, the output-level register holds all ones, the fault-enable mask is all zero, and fault_flags and fault_irq are 0.
- R2: Address 0 holds the modes, two bits per pad at bits [2i+1:2i]: 00 is input, 01 is static output, and 10 or 11 is blink.
- R3: A pad in static-output mode has pad_oe high when bit i of the output-level register (address 1) is 0, and low when that bit is 1. A pad in input mode never has pad_oe high. A register write takes effect on pad_oe in the cycle after its clock edge.
- R4: Every pad in blink mode drives pad_oe from one shared phase. That phase toggles once every TICK_DIV*BLINK_TICKS clock cycles, so all blinking pads always show the same pad_oe value.
- R5: in_level[i] shows pad_in[i] after two clock edges, for every pad.
- R6: When the synchronized level of an input-mode pad changes in either direction, fault_flags[i] goes high on the third clock edge after the pad change. A change on a pad that is not in input mode sets no flag.
- R7: Fault flags stay set until cleared. Writing address 3 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 untouched.
- R8: fault_irq is high exactly when some flag is set and its bit in the fault-enable mask (address 2) is 1. A masked flag does not raise fault_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 modes, 1 output levels, 2 fault mask, 3 fault clear |
| wr_data | input | 2*N_PINS | Write data |
| pad_in | input | N_PINS | Pad levels as seen at the pins |
| pad_oe | output | N_PINS | Pull-down enable per pad (the driven value is always 0) |
| in_level | output | N_PINS | Synchronized pad levels |
| fault_flags | output | N_PINS | Sticky level-change flags |
| fault_irq | output | 1 | High while any enabled flag is set |

## Verification
Random sequences mix mode, level, mask and clear writes with random external pad levels. Flags are compared only after every pad has had time to settle. These sequences show whether flags come from input pads alone, whether a clear removes only the selected bits, and whether the mask gates the fault line. Directed cases time the two-edge input path exactly. They also check that a static output pad whose external level toggles raises no flag. Finally, they measure the blink half-period between two phase changes and confirm that all blinking pads move together.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int N_PINS      = 4,
  parameter int TICK_DIV    = 5000,
  parameter int BLINK_TICKS = 16667,
  localparam int DW = 2 * N_PINS,
  localparam int TW = $clog2(TICK_DIV + 1),
  localparam int BW = $clog2(BLINK_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [N_PINS-1:0] pad_in,
  output logic [N_PINS-1:0] pad_oe,
  output logic [N_PINS-1:0] in_level,
  output logic [N_PINS-1:0] fault_flags,
  output logic              fault_irq
);

  logic [DW-1:0]     mode_q;
  logic [N_PINS-1:0] level_q, mask_q, flag_q;
  logic [N_PINS-1:0] sync1, sync2, prev;
  logic [N_PINS-1:0] is_in, change;
  logic [TW-1:0]     tick_cnt;
  logic [BW-1:0]     blink_cnt;
  logic              phase;

  wire tick       = tick_cnt == TW'(TICK_DIV - 1);
  wire blink_wrap = tick && (blink_cnt == BW'(BLINK_TICKS - 1));
  wire wr_mode    = wr_en && wr_addr == 2'd0;
  wire wr_level   = wr_en && wr_addr == 2'd1;
  wire wr_mask    = wr_en && wr_addr == 2'd2;
  wire wr_clr     = wr_en && wr_addr == 2'd3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt  <= '0;
      blink_cnt <= '0;
      phase     <= 1'b0;
    end else begin
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
      if (tick) blink_cnt <= blink_wrap ? '0 : blink_cnt + 1'b1;
      if (blink_wrap) phase <= ~phase;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      level_q <= '1;
      mask_q  <= '0;
    end else begin
      if (wr_mode)  mode_q  <= wr_data;
      if (wr_level) level_q <= wr_data[N_PINS-1:0];
      if (wr_mask)  mask_q  <= wr_data[N_PINS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1  <= '1;
      sync2  <= '1;
      prev   <= '1;
      flag_q <= '0;
    end else begin
      sync1  <= pad_in;
      sync2  <= sync1;
      prev   <= sync2;
      flag_q <= (flag_q & ~(wr_clr ? wr_data[N_PINS-1:0] : '0)) | change;
    end
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    assign is_in[i]  = mode_q[2*i+1:2*i] == 2'b00;
    assign pad_oe[i] = mode_q[2*i+1] ? phase : (mode_q[2*i] & ~level_q[i]);
    assign change[i] = is_in[i] & (sync2[i] ^ prev[i]);

    AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      is_in[i] |-> !pad_oe[i]); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[i] && !(wr_clr && wr_data[i]) |=> flag_q[i]); // R7
    AST_FLAG_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[i]) |-> $past(is_in[i])); // R6
  end

  assign in_level    = sync2;
  assign fault_flags = flag_q;
  assign fault_irq   = |(flag_q & mask_q);

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !blink_wrap |=> $stable(phase)); // R4
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q == '0) |-> !fault_irq); // R8

endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  localparam int N = 4;
  localparam int TD = 4;
  localparam int BT = 5;
  localparam int HALF = TD * BT;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [2*N-1:0] wr_data = 0;
  logic [N-1:0] ext = '1;
  logic [N-1:0] pad_in, pad_oe, in_level, fault_flags;
  logic fault_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [2*N-1:0] m_mode = 0;
  logic [N-1:0] m_level = '1, m_mask = 0, m_flags = 0;

  assign pad_in = ext & ~pad_oe;
  always #2 clk = ~clk;

  gpio_bank #(.N_PINS(N), .TICK_DIV(TD), .BLINK_TICKS(BT)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pad_in(pad_in), .pad_oe(pad_oe), .in_level(in_level),
    .fault_flags(fault_flags), .fault_irq(fault_irq));

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [2*N-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [N-1:0] in_mask(logic [2*N-1:0] md);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = md[2*i+1 -: 2] == 2'b00;
    return r;
  endfunction

  function automatic logic exp_oe(logic [2*N-1:0] md, logic [N-1:0] lv, int i);
    if (md[2*i+1]) return 1'bx;
    return md[2*i] & ~lv[i];
  endfunction

  task automatic settle_and_clear();
    cycles(5);
    wr(2'd3, '1);
    m_flags = 0;
  endtask

  task automatic check_all();
    logic [N-1:0] im = in_mask(m_mode);
    for (int i = 0; i < N; i++) begin
      if (!m_mode[2*i+1]) check(pad_oe[i] == exp_oe(m_mode, m_level, i), "R2 R3 pad_oe", pad_oe[i], exp_oe(m_mode, m_level, i));
      if (im[i]) check(in_level[i] == ext[i], "R5 in_level", in_level[i], ext[i]);
    end
    check(fault_flags == m_flags, "R6 R7 flags", fault_flags, m_flags);
    check(fault_irq == |(m_flags & m_mask), "R8 irq", fault_irq, |(m_flags & m_mask));
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] nv;
    int cnt;
    logic p0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(pad_oe == 0, "R1 pad_oe", pad_oe, 0);
    check(fault_flags == 0, "R1 flags", fault_flags, 0);
    check(fault_irq == 0, "R1 irq", fault_irq, 0);
    check(in_level == '1, "R1 in_level", in_level, 4'hf);

    // R3 static low on pin 0, released on others; output visible next cycle
    wr(2'd1, 8'h0E);
    wr(2'd0, 8'h55);
    m_level = 4'hE; m_mode = 8'h55;
    check(pad_oe == 4'h1, "R3 static output", pad_oe, 1);
    settle_and_clear();
    // R6 released output pad toggled externally: no flag
    ext = 4'hD; cycles(4);
    check(fault_flags == 0, "R6 non-input no flag", fault_flags, 0);
    ext = 4'hF; cycles(4);

    // R5 exact two-edge latency
    wr(2'd0, 8'h00); m_mode = 0;
    settle_and_clear();
    ext = 4'h7;
    @(posedge clk); @(negedge clk);
    check(in_level == 4'hF, "R5 one edge old", in_level, 4'hF);
    @(posedge clk); @(negedge clk);
    check(in_level == 4'h7, "R5 two edges new", in_level, 4'h7);
    check(fault_flags == 0, "R6 not yet flagged", fault_flags, 0);
    @(posedge clk); @(negedge clk);
    check(fault_flags == 4'h8, "R6 third edge flag", fault_flags, 8);
    check(fault_irq == 0, "R8 masked flag", fault_irq, 0);
    wr(2'd2, 8'h08);
    check(fault_irq == 1, "R8 enabled flag", fault_irq, 1);
    wr(2'd3, 8'h07);
    check(fault_flags == 4'h8, "R7 clear other bits no effect", fault_flags, 8);
    wr(2'd3, 8'h08);
    check(fault_flags == 0 && fault_irq == 0, "R7 clear", fault_flags, 0);
    ext = 4'hF; cycles(4);
    check(fault_flags == 4'h8, "R6 rising edge flag", fault_flags, 8);
    wr(2'd3, 8'hFF); wr(2'd2, 8'h00);

    // R4 blink: shared phase and half period
    wr(2'd0, 8'hAE);
    cnt = 0; p0 = pad_oe[0];
    while (pad_oe[0] == p0 && cnt < 200) begin @(negedge clk); cnt++; end
    p0 = pad_oe[0]; cnt = 0;
    while (pad_oe[0] == p0 && cnt < 200) begin
      check(pad_oe[1] == pad_oe[0] && pad_oe[2] == pad_oe[0] && pad_oe[3] == pad_oe[0], "R4 in phase", pad_oe, {4{pad_oe[0]}});
      @(negedge clk); cnt++;
    end
    check(cnt == HALF, "R4 half period", cnt, HALF);

    // random mix
    wr(2'd0, 8'h00); m_mode = 0;
    wr(2'd1, 8'hFF); m_level = '1;
    m_mask = 0;
    settle_and_clear();
    for (int it = 0; it < 300; it++) begin
      case ($urandom % 5)
        0: begin m_mode = 8'($urandom); wr(2'd0, m_mode); settle_and_clear(); end
        1: begin m_level = 4'($urandom); wr(2'd1, {4'h0, m_level}); settle_and_clear(); end
        2: begin m_mask = 4'($urandom); wr(2'd2, {4'h0, m_mask}); end
        3: begin nv = 4'($urandom); wr(2'd3, {4'h0, nv}); m_flags &= ~nv; end
        default: begin
          nv = 4'($urandom);
          m_flags |= (ext ^ nv) & in_mask(m_mode);
          ext = nv; cycles(4);
        end
      endcase
      check_all();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule